// File: doc/BRIEF.md
# Scrolling Mirrored Row Scan Generator

This block runs the display refresh for a 48-row by 84-column dot-matrix panel. Each pulse on the row-step input starts the next display row slot. The slots run 0 to 47 and then wrap, so the panel is scanned continuously frame after frame. For every slot the block works out which row of the display RAM feeds that slot. It then issues a read for the RAM bank that holds that row, picks the matching bit out of every byte of the returned bank word, and presents 84 column bits together with the slot number.

The slot-to-RAM-row mapping has two controls. A scroll offset rotates the picture modulo the row count. A vertical mirror bit reverses the scan so that the offset row lands on the last display row instead of the first. Neither control writes the RAM. A change to either one applies from the next row started.

Three mode inputs shape the column bits. They give a blanked display, all dots lit, and inverse video. When "display off" and "all dots" are both set, the block is in power-down and the columns are held inactive.

Top module: `vscan_row_engine`

## Requirements
- R1: After reset the first row-step starts display slot 0. Each later row-step starts the next slot, and slot 47 is followed by slot 0. `row_idx` reports the slot of the row being presented.
- R2: A row-step sampled high at a clock edge raises `ram_rd_en` for one cycle after that edge. The RAM must return `ram_rd_data` on the cycle after `ram_rd_en` (one-cycle read latency). `col_data`, `row_idx`, `row_strobe` and `frame_start` update on the edge after the data arrives, and `col_data` holds between rows.
- R3: With `mirror_y`=0, display slot s shows RAM row (Z + s) mod 48.
- R4: With `mirror_y`=1, display slot s shows RAM row (Z + 47 − s) mod 48. Slot 47 therefore shows RAM row Z, and slot 46 shows row Z+1.
- R5: A scroll value of 48 to 63 on the 6-bit `scroll_z` input acts as that value minus 48.
- R6: RAM row r is read from bank r/8, driven on `ram_bank`. Column c takes bit (r mod 8) of byte c of the bank word, and byte c occupies `ram_rd_data[8c+7:8c]`.
- R7: With `disp_en`=0 and `all_pts`=1 (power-down), every column bit is 0, whatever the RAM data and `inv_video` are.
- R8: With `disp_en`=1 and `all_pts`=1, every column bit is 1, whatever the RAM data and `inv_video` are.
- R9: With `disp_en`=0 and `all_pts`=0, every column bit is 0.
- R10: With `disp_en`=1 and `all_pts`=0, column bits equal the RAM bits, inverted when `inv_video`=1.
- R11: `frame_start` pulses together with `row_strobe` exactly when slot 0 is presented, and at no other time.
- R12: A change of `scroll_z` or `mirror_y` between two row-steps applies from the very next row without waiting for a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_step | input | 1 | One-cycle pulse: start the next display row slot |
| scroll_z | input | 6 | Vertical scroll offset |
| mirror_y | input | 1 | Vertical mirror enable |
| disp_en | input | 1 | Display on |
| all_pts | input | 1 | All dots mode |
| inv_video | input | 1 | Inverse video |
| ram_bank | output | 3 | RAM bank to read |
| ram_rd_en | output | 1 | RAM read request |
| ram_rd_data | input | 672 | Bank word: 84 bytes, byte c at bits 8c+7..8c |
| row_idx | output | 6 | Display slot of the presented row |
| row_strobe | output | 1 | One-cycle pulse: new row on outputs |
| frame_start | output | 1 | One-cycle pulse with slot 0 |
| col_data | output | 84 | Column bits for the presented row |

## Verification
A slot counter that drifts or skips shows up on the very next `row_strobe` as a wrong `row_idx`, and one frame later as a `frame_start` in the wrong place. An error in the scroll or mirror arithmetic shows up within one row as a wrong `ram_bank` or wrong column bits, because the bench fills each RAM row with its own pattern. An error in bit selection or mode priority changes `col_data` on the first row that uses the affected mode. The bench therefore compares every row against a model, under each mode and for several offsets in both scan directions.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

  typedef enum logic [1:0] {
    COL_BLANK   = 2'd0,
    COL_FULL    = 2'd1,
    COL_RAM     = 2'd2,
    COL_RAM_INV = 2'd3
  } col_src_e;

  // Power-down wins, then all dots, then display off, then RAM data.
  function automatic col_src_e pick_src(input logic disp_en,
                                        input logic all_pts,
                                        input logic inv_video);
    if (!disp_en && all_pts)
      return COL_BLANK;
    else if (all_pts)
      return COL_FULL;
    else if (!disp_en)
      return COL_BLANK;
    else if (inv_video)
      return COL_RAM_INV;
    else
      return COL_RAM;
  endfunction

endpackage

// File: rtl/vscan_slot_ctr.sv
module vscan_slot_ctr #(
  parameter int NUM_ROWS = 48,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] slot
);

  localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      slot <= '0;
    else if (step)
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && slot == LAST) |=> (slot == '0)); // R1

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(slot)); // R1

endmodule

// File: rtl/vscan_row_map.sv
module vscan_row_map #(
  parameter int NUM_ROWS  = 48,
  parameter int BANK_ROWS = 8,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int NUM_BANKS = (NUM_ROWS + BANK_ROWS - 1) / BANK_ROWS,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BIT_W     = (BANK_ROWS > 1) ? $clog2(BANK_ROWS) : 1
) (
  input  logic [ROW_W-1:0]  slot,
  input  logic [ROW_W-1:0]  scroll_z,
  input  logic              mirror_y,
  output logic [ROW_W-1:0]  ram_row,
  output logic [BANK_W-1:0] bank,
  output logic [BIT_W-1:0]  bit_sel
);

  localparam logic [ROW_W:0]   N_EXT = (ROW_W + 1)'(NUM_ROWS);
  localparam logic [ROW_W-1:0] BR    = ROW_W'(BANK_ROWS);

  logic [ROW_W:0] z_ext;
  logic [ROW_W:0] z_eff;
  logic [ROW_W:0] offs;
  logic [ROW_W:0] sum;

  always_comb begin
    z_ext   = {1'b0, scroll_z};
    z_eff   = (z_ext >= N_EXT) ? z_ext - N_EXT : z_ext;
    offs    = mirror_y ? (N_EXT - 1'b1 - {1'b0, slot}) : {1'b0, slot};
    sum     = z_eff + offs;
    ram_row = ROW_W'((sum >= N_EXT) ? sum - N_EXT : sum);
    bank    = BANK_W'(ram_row / BR);
    bit_sel = BIT_W'(ram_row % BR);
  end

endmodule

// File: rtl/vscan_bit_pick.sv
module vscan_bit_pick #(
  parameter int NUM_COLS  = 84,
  parameter int BANK_ROWS = 8,
  localparam int BIT_W  = (BANK_ROWS > 1) ? $clog2(BANK_ROWS) : 1,
  localparam int WORD_W = NUM_COLS * BANK_ROWS
) (
  input  logic [WORD_W-1:0]   bank_word,
  input  logic [BIT_W-1:0]    bit_sel,
  output logic [NUM_COLS-1:0] cols
);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [BANK_ROWS-1:0] col_byte;
    assign col_byte = bank_word[c*BANK_ROWS +: BANK_ROWS];
    assign cols[c]  = col_byte[bit_sel];
  end

endmodule

// File: rtl/vscan_col_mode.sv
module vscan_col_mode
  import vscan_pkg::*;
#(
  parameter int NUM_COLS = 84
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [NUM_COLS-1:0] ram_cols,
  input  logic                disp_en,
  input  logic                all_pts,
  input  logic                inv_video,
  output logic [NUM_COLS-1:0] col_out
);

  col_src_e src;

  always_comb src = pick_src(disp_en, all_pts, inv_video);

  always_ff @(posedge clk) begin
    if (rst)
      col_out <= '0;
    else if (load) begin
      case (src)
        COL_FULL:    col_out <= '1;
        COL_RAM:     col_out <= ram_cols;
        COL_RAM_INV: col_out <= ~ram_cols;
        default:     col_out <= '0;
      endcase
    end
  end

  AST_PD_BLANK: assert property (@(posedge clk) disable iff (rst)
    (load && !disp_en && all_pts) |=> (col_out == '0)); // R7

  AST_ALL_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (load && disp_en && all_pts) |=> (col_out == '1)); // R8

  AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(col_out)); // R2

endmodule

// File: rtl/vscan_row_engine.sv
module vscan_row_engine #(
  parameter int NUM_ROWS  = 48,
  parameter int NUM_COLS  = 84,
  parameter int BANK_ROWS = 8,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int NUM_BANKS = (NUM_ROWS + BANK_ROWS - 1) / BANK_ROWS,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BIT_W     = (BANK_ROWS > 1) ? $clog2(BANK_ROWS) : 1,
  localparam int WORD_W    = NUM_COLS * BANK_ROWS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                row_step,
  input  logic [ROW_W-1:0]    scroll_z,
  input  logic                mirror_y,
  input  logic                disp_en,
  input  logic                all_pts,
  input  logic                inv_video,
  output logic [BANK_W-1:0]   ram_bank,
  output logic                ram_rd_en,
  input  logic [WORD_W-1:0]   ram_rd_data,
  output logic [ROW_W-1:0]    row_idx,
  output logic                row_strobe,
  output logic                frame_start,
  output logic [NUM_COLS-1:0] col_data
);

  logic [ROW_W-1:0]    slot;
  logic [ROW_W-1:0]    map_row;
  logic [BANK_W-1:0]   map_bank;
  logic [BIT_W-1:0]    map_bit;

  // stage 1: read issued
  logic [ROW_W-1:0]    s1_slot;
  logic [BIT_W-1:0]    s1_bit;
  // stage 2: read data returning
  logic                s2_valid;
  logic [ROW_W-1:0]    s2_slot;
  logic [BIT_W-1:0]    s2_bit;
  logic [NUM_COLS-1:0] picked;

  vscan_slot_ctr #(.NUM_ROWS(NUM_ROWS)) u_slot (
    .clk  (clk),
    .rst  (rst),
    .step (row_step),
    .slot (slot)
  );

  vscan_row_map #(.NUM_ROWS(NUM_ROWS), .BANK_ROWS(BANK_ROWS)) u_map (
    .slot     (slot),
    .scroll_z (scroll_z),
    .mirror_y (mirror_y),
    .ram_row  (map_row),
    .bank     (map_bank),
    .bit_sel  (map_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_rd_en <= 1'b0;
      ram_bank  <= '0;
      s1_slot   <= '0;
      s1_bit    <= '0;
    end else begin
      ram_rd_en <= row_step;
      if (row_step) begin
        ram_bank <= map_bank;
        s1_slot  <= slot;
        s1_bit   <= map_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_slot  <= '0;
      s2_bit   <= '0;
    end else begin
      s2_valid <= ram_rd_en;
      if (ram_rd_en) begin
        s2_slot <= s1_slot;
        s2_bit  <= s1_bit;
      end
    end
  end

  vscan_bit_pick #(.NUM_COLS(NUM_COLS), .BANK_ROWS(BANK_ROWS)) u_pick (
    .bank_word (ram_rd_data),
    .bit_sel   (s2_bit),
    .cols      (picked)
  );

  vscan_col_mode #(.NUM_COLS(NUM_COLS)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .load      (s2_valid),
    .ram_cols  (picked),
    .disp_en   (disp_en),
    .all_pts   (all_pts),
    .inv_video (inv_video),
    .col_out   (col_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx     <= '0;
      row_strobe  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      row_strobe  <= s2_valid;
      frame_start <= s2_valid && (s2_slot == '0);
      if (s2_valid)
        row_idx <= s2_slot;
    end
  end

  AST_MAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    row_step |-> (map_row < ROW_W'(NUM_ROWS))); // R3

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> ({1'b0, ram_bank} < (BANK_W + 1)'(NUM_BANKS))); // R6

  AST_STROBE_LAT: assert property (@(posedge clk) disable iff (rst)
    row_strobe |-> $past(ram_rd_en, 2)); // R2

  AST_FRAME_SLOT0: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_strobe && row_idx == '0)); // R11

endmodule

// File: tb/vscan_row_engine_tb.sv
`timescale 1ns/1ps
module vscan_row_engine_tb;

  localparam int NR = 48;
  localparam int NC = 84;
  localparam int BR = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          row_step;
  logic [5:0]    scroll_z;
  logic          mirror_y, disp_en, all_pts, inv_video;
  logic [2:0]    ram_bank;
  logic          ram_rd_en;
  logic [NC*BR-1:0] ram_rd_data = '0;
  logic [5:0]    row_idx;
  logic          row_strobe, frame_start;
  logic [NC-1:0] col_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int bench_slot = 0;

  logic [5:0]    q_idx[$];
  logic [NC-1:0] q_col[$];
  bit            q_fs[$];
  string         q_tag[$];
  logic [2:0]    q_bank[$];

  always #4 clk = ~clk;

  vscan_row_engine u_dut (
    .clk(clk), .rst(rst), .row_step(row_step), .scroll_z(scroll_z),
    .mirror_y(mirror_y), .disp_en(disp_en), .all_pts(all_pts),
    .inv_video(inv_video), .ram_bank(ram_bank), .ram_rd_en(ram_rd_en),
    .ram_rd_data(ram_rd_data), .row_idx(row_idx), .row_strobe(row_strobe),
    .frame_start(frame_start), .col_data(col_data)
  );

  function automatic bit pat(int r, int c);
    return ((r * 5 + c * 3 + (r * c) % 7) % 3) == 0;
  endfunction

  // RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (ram_rd_en)
      for (int b = 0; b < BR; b++)
        for (int c = 0; c < NC; c++)
          ram_rd_data[c*BR+b] <= pat(int'(ram_bank) * BR + b, c);
  end

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ram_rd_en) begin
        if (q_bank.size() == 0) check("R2 unexpected read", 128'd1, 128'd0);
        else check("R6 bank", 128'(ram_bank), 128'(q_bank.pop_front()));
      end
      if (row_strobe) begin
        if (q_idx.size() == 0) check("R2 unexpected strobe", 128'd1, 128'd0);
        else begin
          string t;
          t = q_tag.pop_front();
          check({t, " R1 row_idx"}, 128'(row_idx), 128'(q_idx.pop_front()));
          check({t, " R6 col_data"}, 128'(col_data), 128'(q_col.pop_front()));
          check({t, " R11 frame_start"}, 128'(frame_start), 128'(q_fs.pop_front()));
        end
      end
    end
  end

  // driver
  task automatic do_row(string tag);
    int s, z, r;
    logic [NC-1:0] exp;
    s = bench_slot;
    z = int'(scroll_z) % NR;
    r = mirror_y ? (z + NR - 1 - s) % NR : (z + s) % NR;
    for (int c = 0; c < NC; c++) exp[c] = pat(r, c);
    if (!disp_en && all_pts) exp = '0;
    else if (all_pts)        exp = '1;
    else if (!disp_en)       exp = '0;
    else if (inv_video)      exp = ~exp;
    q_idx.push_back(6'(s));
    q_col.push_back(exp);
    q_fs.push_back(s == 0);
    q_tag.push_back(tag);
    q_bank.push_back(3'(r / BR));
    @(negedge clk) row_step = 1'b1;
    @(negedge clk) row_step = 1'b0;
    repeat (4) @(negedge clk);
    bench_slot = (s + 1) % NR;
  endtask

  task automatic rows(int n, string tag);
    for (int i = 0; i < n; i++) do_row(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; row_step = 1'b0; scroll_z = '0; mirror_y = 1'b0;
    disp_en = 1'b1; all_pts = 1'b0; inv_video = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset rd_en", 128'(ram_rd_en), 128'd0);
    check("R1 reset strobe", 128'(row_strobe), 128'd0);
    check("R11 reset frame_start", 128'(frame_start), 128'd0);
    check("R1 reset row_idx", 128'(row_idx), 128'd0);
    check("R9 reset col_data", 128'(col_data), 128'd0);

    rows(NR, "R3 z0");
    scroll_z = 6'd31;
    rows(10, "R3 z31");
    mirror_y = 1'b1;
    rows(NR, "R4 mirror z31");
    mirror_y = 1'b0; scroll_z = 6'd50;
    rows(4, "R5 z50");
    scroll_z = 6'd63; mirror_y = 1'b1;
    rows(3, "R5 z63 mirror");
    mirror_y = 1'b0; scroll_z = 6'd7;
    inv_video = 1'b1;
    rows(3, "R10 inverse");
    all_pts = 1'b1;
    rows(3, "R8 all on");
    all_pts = 1'b0; disp_en = 1'b0; inv_video = 1'b0;
    rows(2, "R9 off");
    all_pts = 1'b1; inv_video = 1'b1;
    rows(3, "R7 power-down");
    disp_en = 1'b1; all_pts = 1'b0; inv_video = 1'b0;
    rows(2, "R10 normal");
    mirror_y = 1'b1; scroll_z = 6'd5;
    rows(2, "R12 change");
    scroll_z = 6'd40;
    rows(2, "R12 change");
    mirror_y = 1'b0;
    rows(2, "R12 change");

    repeat (6) @(negedge clk);
    check("R2 rows outstanding", 128'(q_idx.size()), 128'd0);
    check("R2 reads outstanding", 128'(q_bank.size()), 128'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule